// File: doc/BRIEF.md
# Trace status sequencer

This block drives a core's real-time trace output. A simplified core model raises one-cycle event pulses for these events: exception entry, emulator-mode exception entry, reset, halt, stop, return-from-exception, status-register write and a plain one-cycle supervisor instruction. For each accepted event the sequencer produces a fixed, event-specific run of trace entries. Each entry holds a processor-status code, a data-valid flag and a 32-bit data word. The entries leave through a ready-gated output, one per cycle while `trcReady` is high.

Each event brings four operand words (A to D), a four-bit capture-enable mask and a target-code select. These decide which optional entries appear and what they carry. Events are held in a small queue in arrival order. The block raises `busy` when the queue is full, and the core must hold back new events while it is high. When the queue is empty, the output carries the idle continue code 0x00.

Top module: `trace_seq`

## Requirements
- R1: While `rstN` is low, `trcValid` is 0. From the first clock edge after reset release, `trcValid` is 1. While no event is queued, the output is code 0x00 with `trcDv`=0 and `trcData`=0.
- R2: A normal exception (`evtKind`=0) emits 0x1C, 0x1C, then three optional groups, then 0x05. The first optional group is two 0x0B entries carrying A and B, present when `evtEn[0]`=1. The second is one 0x0B entry carrying C, present when `evtEn[1]`=1. The third comes after 0x05: a target entry carrying D, present when `evtEn[2]`=1.
- R3: An emulator-mode exception (`evtKind`=1) emits the same sequence as R2, but with 0x1D in both leading entries.
- R4: A reset event (`evtKind`=2) emits 0x1C, 0x1C, 0x05, then the target entry carrying D when `evtEn[2]`=1. `evtEn[0]`, `evtEn[1]` and `evtEn[3]` add no entries.
- R5: A halt (`evtKind`=3) emits 0x1F twice. A stop (`evtKind`=4) emits 0x1E twice.
- R6: A return-from-exception (`evtKind`=5) emits these entries in this order:
  - 0x07;
  - 0x0B carrying A, if `evtEn[0]`=1;
  - 0x03, if `evtEn[1]`=1;
  - 0x0B carrying B, if `evtEn[3]`=1;
  - 0x05;
  - the target entry carrying D, if `evtEn[2]`=1.
- R7: A status-register write (`evtKind`=6) emits 0x01, followed by 0x03 when `evtEn[1]`=1. A plain supervisor instruction (`evtKind`=7) emits a single 0x01.
- R8: The target entry's code is 0x0D when `evtTgtSel`=0 and 0x0E when `evtTgtSel`=1.
- R9: `trcDv` is 1 exactly on entries that carry an operand (0x0B and target entries). On all other entries `trcData` is 0.
- R10: Accepted events are emitted whole, one after another, in arrival order, with no interleaving. An event accepted while the queue is empty shows its first entry in the cycle after it was accepted.
- R11: `busy` is 1 when DEPTH events are held, counting the one being emitted. An event presented while `busy` is 1 is ignored.
- R12: An entry stays on the output, and the sequence does not advance, while `trcReady` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Event pulse |
| evtKind | input | 3 | Event kind, encoded as 0..7 per R2-R7 |
| evtEn | input | 4 | Capture enables for optional entries |
| evtTgtSel | input | 1 | Target code select (0: 0x0D, 1: 0x0E) |
| evtOpA | input | 32 | Operand A (first frame / first source) |
| evtOpB | input | 32 | Operand B (second frame / second source) |
| evtOpC | input | 32 | Operand C (vector read) |
| evtOpD | input | 32 | Operand D (target address) |
| busy | output | 1 | Event queue full |
| trcReady | input | 1 | Trace sink accepts an entry |
| trcValid | output | 1 | Trace output running |
| trcCode | output | 8 | Processor-status code |
| trcDv | output | 1 | Entry carries data |
| trcData | output | 32 | Entry data |

## Verification
Directed events of every kind are run first with all capture enables off, then all on, then with single bits set. This separates the unconditional script skeleton from each optional entry and shows that the reset script ignores the enables that add stack-frame and source entries. Both target-select values are used, so the two target codes are told apart.

A burst of events sent with the sink stalled fills the queue. The extra events sent then must disappear without a trace, and the burst shows whether `busy` counts the in-progress event. A long run with random events and random `trcReady` is then compared against a queue-based model cycle by cycle. That run catches ordering slips, interleaving and any advance made while not ready.

// File: rtl/trace_seq_pkg.sv
package trace_seq_pkg;

  localparam int DATA_W = 32;
  localparam int CODE_W = 8;
  localparam int SLOTS  = 8;
  localparam int IDX_W  = $clog2(SLOTS);

  typedef enum logic [2:0] {
    EV_EXC, EV_EMU, EV_RST, EV_HALT, EV_STOP, EV_RTE, EV_SRW, EV_SUP
  } evKind_e;

  typedef enum logic [2:0] {SEL_NONE, SEL_A, SEL_B, SEL_C, SEL_D} dSel_e;

  // gate: 0 = always, n = evtEn[n-1] must be set
  typedef struct packed {
    logic              used;
    logic [CODE_W-1:0] code;
    dSel_e             sel;
    logic [2:0]        gate;
  } slot_t;

  typedef struct packed {
    evKind_e           kind;
    logic [3:0]        en;
    logic              tgtSel;
    logic [DATA_W-1:0] opA;
    logic [DATA_W-1:0] opB;
    logic [DATA_W-1:0] opC;
    logic [DATA_W-1:0] opD;
  } evt_t;

  typedef struct packed {
    logic              wrEn;
    logic              emit;
    logic [CODE_W-1:0] code;
    dSel_e             sel;
  } strobe_t;

  function automatic slot_t mkSlot(logic [CODE_W-1:0] c, dSel_e s, logic [2:0] g);
    slot_t r;
    r.used = 1'b1;
    r.code = c;
    r.sel  = s;
    r.gate = g;
    return r;
  endfunction

  // Per-event script: slot list, walked in index order, disabled slots skipped
  function automatic slot_t scriptSlot(evKind_e k, logic [IDX_W-1:0] idx, logic tgtSel);
    slot_t s;
    logic [CODE_W-1:0] tgt;
    logic [CODE_W-1:0] mark;
    s    = '0;
    tgt  = tgtSel ? 8'h0E : 8'h0D;
    mark = (k == EV_EMU) ? 8'h1D : 8'h1C;
    case (k)
      EV_EXC, EV_EMU: begin
        case (idx)
          3'd0, 3'd1: s = mkSlot(mark, SEL_NONE, 3'd0);
          3'd2:       s = mkSlot(8'h0B, SEL_A, 3'd1);
          3'd3:       s = mkSlot(8'h0B, SEL_B, 3'd1);
          3'd4:       s = mkSlot(8'h0B, SEL_C, 3'd2);
          3'd5:       s = mkSlot(8'h05, SEL_NONE, 3'd0);
          3'd6:       s = mkSlot(tgt, SEL_D, 3'd3);
          default:    s = '0;
        endcase
      end
      EV_RST: begin
        case (idx)
          3'd0, 3'd1: s = mkSlot(8'h1C, SEL_NONE, 3'd0);
          3'd2:       s = mkSlot(8'h05, SEL_NONE, 3'd0);
          3'd3:       s = mkSlot(tgt, SEL_D, 3'd3);
          default:    s = '0;
        endcase
      end
      EV_HALT: if (idx < 3'd2) s = mkSlot(8'h1F, SEL_NONE, 3'd0);
      EV_STOP: if (idx < 3'd2) s = mkSlot(8'h1E, SEL_NONE, 3'd0);
      EV_RTE: begin
        case (idx)
          3'd0:    s = mkSlot(8'h07, SEL_NONE, 3'd0);
          3'd1:    s = mkSlot(8'h0B, SEL_A, 3'd1);
          3'd2:    s = mkSlot(8'h03, SEL_NONE, 3'd2);
          3'd3:    s = mkSlot(8'h0B, SEL_B, 3'd4);
          3'd4:    s = mkSlot(8'h05, SEL_NONE, 3'd0);
          3'd5:    s = mkSlot(tgt, SEL_D, 3'd3);
          default: s = '0;
        endcase
      end
      EV_SRW: begin
        case (idx)
          3'd0:    s = mkSlot(8'h01, SEL_NONE, 3'd0);
          3'd1:    s = mkSlot(8'h03, SEL_NONE, 3'd2);
          default: s = '0;
        endcase
      end
      default: if (idx == 3'd0) s = mkSlot(8'h01, SEL_NONE, 3'd0);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/trace_seq_ctrl.sv
module trace_seq_ctrl
  import trace_seq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtValid,
  input  logic             trcReady,
  input  evKind_e          headKind,
  input  logic [3:0]       headEn,
  input  logic             headTgtSel,
  output strobe_t          stb,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             busy
);

  logic [CNT_W-1:0] count;
  logic [PTR_W-1:0] wrPtrQ, rdPtrQ;
  logic [IDX_W-1:0] idxQ, curIdx;
  slot_t            curSlot;
  logic             found, moreAfter, push, pop, advance;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // First enabled slot at or after idxQ, and whether another follows it
  always_comb begin
    logic [7:0] gateVec;
    slot_t      s;
    logic       ok;
    gateVec   = {3'b000, headEn, 1'b1};
    found     = 1'b0;
    moreAfter = 1'b0;
    curIdx    = '0;
    curSlot   = '0;
    for (int j = 0; j < SLOTS; j++) begin
      s  = scriptSlot(headKind, IDX_W'(j), headTgtSel);
      ok = s.used && gateVec[s.gate] && (IDX_W'(j) >= idxQ);
      if (ok && found) begin
        moreAfter = 1'b1;
      end else if (ok) begin
        found   = 1'b1;
        curIdx  = IDX_W'(j);
        curSlot = s;
      end
    end
  end

  assign busy     = (count == CNT_W'(DEPTH));
  assign push     = evtValid && !busy;
  assign advance  = (count != '0) && found && trcReady;
  assign pop      = advance && !moreAfter;

  assign stb.wrEn = push;
  assign stb.emit = (count != '0) && found;
  assign stb.code = curSlot.code;
  assign stb.sel  = curSlot.sel;
  assign wrPtr    = wrPtrQ;
  assign rdPtr    = rdPtrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      wrPtrQ <= '0;
      rdPtrQ <= '0;
      idxQ   <= '0;
    end else begin
      if (push) wrPtrQ <= bump(wrPtrQ);
      if (pop)  rdPtrQ <= bump(rdPtrQ);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (advance) idxQ <= moreAfter ? curIdx + 1'b1 : '0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R11
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !pop) |=> busy); // R11
  AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    ((count != '0) && !trcReady) |=> ($stable(idxQ) && $stable(rdPtrQ))); // R12
  AST_NEXT_STARTS_FRESH: assert property (@(posedge clk) disable iff (!rstN)
    pop |=> (idxQ == '0)); // R10

endmodule

// File: rtl/trace_seq_dp.sv
module trace_seq_dp
  import trace_seq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  evt_t              evtIn,
  output evKind_e           headKind,
  output logic [3:0]        headEn,
  output logic              headTgtSel,
  output logic              trcValid,
  output logic [CODE_W-1:0] trcCode,
  output logic              trcDv,
  output logic [DATA_W-1:0] trcData
);

  evt_t store [DEPTH];
  evt_t head;
  logic runQ;
  logic [DATA_W-1:0] pick;

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)                                   store[g] <= '0;
      else if (stb.wrEn && wrPtr == PTR_W'(g))     store[g] <= evtIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) runQ <= 1'b0;
    else       runQ <= 1'b1;
  end

  assign head       = store[rdPtr];
  assign headKind   = head.kind;
  assign headEn     = head.en;
  assign headTgtSel = head.tgtSel;

  always_comb begin
    case (stb.sel)
      SEL_A:   pick = head.opA;
      SEL_B:   pick = head.opB;
      SEL_C:   pick = head.opC;
      SEL_D:   pick = head.opD;
      default: pick = '0;
    endcase
  end

  assign trcValid = runQ;
  assign trcCode  = stb.emit ? stb.code : '0;
  assign trcDv    = stb.emit && (stb.sel != SEL_NONE);
  assign trcData  = trcDv ? pick : '0;

  AST_DV_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    trcDv |-> (trcCode == 8'h0B || trcCode == 8'h0D || trcCode == 8'h0E)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !stb.emit |-> (trcCode == '0 && !trcDv && trcData == '0)); // R1

endmodule

// File: rtl/trace_seq.sv
module trace_seq
  import trace_seq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtValid,
  input  logic [2:0]  evtKind,
  input  logic [3:0]  evtEn,
  input  logic        evtTgtSel,
  input  logic [31:0] evtOpA,
  input  logic [31:0] evtOpB,
  input  logic [31:0] evtOpC,
  input  logic [31:0] evtOpD,
  output logic        busy,
  input  logic        trcReady,
  output logic        trcValid,
  output logic [7:0]  trcCode,
  output logic        trcDv,
  output logic [31:0] trcData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  strobe_t          stb;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  evKind_e          headKind;
  logic [3:0]       headEn;
  logic             headTgtSel;
  evt_t             evtIn;

  always_comb begin
    evtIn.kind   = evKind_e'(evtKind);
    evtIn.en     = evtEn;
    evtIn.tgtSel = evtTgtSel;
    evtIn.opA    = evtOpA;
    evtIn.opB    = evtOpB;
    evtIn.opC    = evtOpC;
    evtIn.opD    = evtOpD;
  end

  trace_seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rstN, .evtValid, .trcReady,
    .headKind, .headEn, .headTgtSel,
    .stb, .wrPtr, .rdPtr, .busy
  );

  trace_seq_dp #(.DEPTH(DEPTH)) u_dp (
    .clk, .rstN, .stb, .wrPtr, .rdPtr, .evtIn,
    .headKind, .headEn, .headTgtSel,
    .trcValid, .trcCode, .trcDv, .trcData
  );

endmodule

// File: tb/trace_seq_tb.sv
module trace_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtValid = 1'b0;
  logic [2:0]  evtKind = '0;
  logic [3:0]  evtEn = '0;
  logic        evtTgtSel = 1'b0;
  logic [31:0] evtOpA = '0, evtOpB = '0, evtOpC = '0, evtOpD = '0;
  logic        busy;
  logic        trcReady = 1'b1;
  logic        trcValid;
  logic [7:0]  trcCode;
  logic        trcDv;
  logic [31:0] trcData;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trace_seq #(.DEPTH(DEPTH)) u_dut (
    .clk, .rstN, .evtValid, .evtKind, .evtEn, .evtTgtSel,
    .evtOpA, .evtOpB, .evtOpC, .evtOpD,
    .busy, .trcReady, .trcValid, .trcCode, .trcDv, .trcData
  );

  typedef struct {
    logic [7:0]  code;
    logic        dv;
    logic [31:0] data;
    bit          last;
    string       tag;
  } ent_t;

  ent_t  expQ[$];
  int    evCnt = 0;
  bit    validExp = 0;
  int    nChecks = 0;
  int    nFails = 0;
  bit    finished = 0;

  function automatic void put(logic [7:0] c, bit hasData, logic [31:0] d, string t);
    ent_t e;
    e.code = c; e.dv = hasData; e.data = hasData ? d : 32'h0; e.last = 0; e.tag = t;
    expQ.push_back(e);
  endfunction

  function automatic void expand(int k, logic [3:0] en, bit ts,
                                 logic [31:0] a, logic [31:0] b,
                                 logic [31:0] c, logic [31:0] d);
    logic [7:0] tgt;
    tgt = ts ? 8'h0E : 8'h0D;
    case (k)
      0, 1: begin
        put(k == 0 ? 8'h1C : 8'h1D, 0, 0, k == 0 ? "R2" : "R3");
        put(k == 0 ? 8'h1C : 8'h1D, 0, 0, k == 0 ? "R2" : "R3");
        if (en[0]) begin put(8'h0B, 1, a, "R2"); put(8'h0B, 1, b, "R2"); end
        if (en[1]) put(8'h0B, 1, c, "R2");
        put(8'h05, 0, 0, "R2");
        if (en[2]) put(tgt, 1, d, "R8");
      end
      2: begin
        put(8'h1C, 0, 0, "R4"); put(8'h1C, 0, 0, "R4"); put(8'h05, 0, 0, "R4");
        if (en[2]) put(tgt, 1, d, "R8");
      end
      3: begin put(8'h1F, 0, 0, "R5"); put(8'h1F, 0, 0, "R5"); end
      4: begin put(8'h1E, 0, 0, "R5"); put(8'h1E, 0, 0, "R5"); end
      5: begin
        put(8'h07, 0, 0, "R6");
        if (en[0]) put(8'h0B, 1, a, "R6");
        if (en[1]) put(8'h03, 0, 0, "R6");
        if (en[3]) put(8'h0B, 1, b, "R6");
        put(8'h05, 0, 0, "R6");
        if (en[2]) put(tgt, 1, d, "R8");
      end
      6: begin
        put(8'h01, 0, 0, "R7");
        if (en[1]) put(8'h03, 0, 0, "R7");
      end
      default: put(8'h01, 0, 0, "R7");
    endcase
    expQ[expQ.size() - 1].last = 1;
  endfunction

  // Reference model: advances on each clock edge from pre-edge inputs
  always @(posedge clk) begin
    if (!rstN) begin
      expQ.delete();
      evCnt = 0;
      validExp = 0;
    end else begin
      bit wasFull;
      ent_t e;
      validExp = 1;
      wasFull = (evCnt == DEPTH);
      if (trcReady && expQ.size() > 0) begin
        e = expQ.pop_front();
        if (e.last) evCnt--;
      end
      if (evtValid && !wasFull) begin
        expand(int'(evtKind), evtEn, evtTgtSel, evtOpA, evtOpB, evtOpC, evtOpD);
        evCnt++;
      end
    end
  end

  // Compare on the falling edge, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [7:0]  ec;
      logic        ed;
      logic [31:0] ex;
      string       tg;
      nChecks++;
      if (trcValid !== validExp) begin
        nFails++;
        $display("FAIL R1: trcValid got %b exp %b", trcValid, validExp);
      end
      nChecks++;
      if (busy !== (evCnt == DEPTH)) begin
        nFails++;
        $display("FAIL R11: busy got %b exp %b", busy, (evCnt == DEPTH));
      end
      if (expQ.size() == 0) begin
        ec = 8'h00; ed = 0; ex = 0; tg = "R1";
      end else begin
        ec = expQ[0].code; ed = expQ[0].dv; ex = expQ[0].data; tg = expQ[0].tag;
      end
      nChecks++;
      if (trcCode !== ec || trcDv !== ed || trcData !== ex) begin
        nFails++;
        $display("FAIL %s (R9/R10/R12 ordering): code/dv/data got %h/%b/%h exp %h/%b/%h",
                 tg, trcCode, trcDv, trcData, ec, ed, ex);
      end
    end
  end

  task automatic sendEvt(int k, logic [3:0] en, bit ts, int seed);
    @(negedge clk);
    evtValid  = 1'b1;
    evtKind   = 3'(k);
    evtEn     = en;
    evtTgtSel = ts;
    evtOpA    = 32'hA000_0000 + 32'(seed);
    evtOpB    = 32'hB000_0000 + 32'(seed);
    evtOpC    = 32'hC000_0000 + 32'(seed);
    evtOpD    = 32'hD000_0000 + 32'(seed);
    @(negedge clk);
    evtValid  = 1'b0;
  endtask

  task automatic waitDrain();
    for (int i = 0; i < 200 && (evCnt != 0); i++) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    nChecks++;
    if (trcValid !== 1'b0 || busy !== 1'b0) begin
      nFails++;
      $display("FAIL R1: in reset trcValid/busy got %b/%b exp 0/0", trcValid, busy);
    end
    @(posedge clk);
    #1 rstN = 1'b1;
    repeat (3) @(negedge clk);

    // Directed: each kind, enables off, all on, single bits (R2-R8)
    for (int k = 0; k < 8; k++) begin
      sendEvt(k, 4'b0000, 0, k);
      waitDrain();
      sendEvt(k, 4'b1111, k[0], k + 16);
      waitDrain();
      for (int b = 0; b < 4; b++) begin
        sendEvt(k, 4'(1 << b), b[0], k * 4 + b);
        waitDrain();
      end
    end

    // Fill with sink stalled; extra events must be ignored (R11, R12)
    @(negedge clk);
    trcReady = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      @(negedge clk);
      evtValid = 1'b1; evtKind = 3'(i % 8); evtEn = 4'b1111;
      evtTgtSel = 1'(i); evtOpA = 32'(i); evtOpB = 32'(i + 100);
      evtOpC = 32'(i + 200); evtOpD = 32'(i + 300);
    end
    @(negedge clk);
    evtValid = 1'b0;
    repeat (5) @(negedge clk);
    trcReady = 1'b1;
    waitDrain();

    // Random events with random back-pressure (R10, R12)
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      evtValid  = ($urandom_range(0, 99) < 30);
      evtKind   = 3'($urandom_range(0, 7));
      evtEn     = 4'($urandom_range(0, 15));
      evtTgtSel = 1'($urandom_range(0, 1));
      evtOpA    = $urandom; evtOpB = $urandom;
      evtOpC    = $urandom; evtOpD = $urandom;
      trcReady  = ($urandom_range(0, 99) < 70);
    end
    @(negedge clk);
    evtValid = 1'b0;
    trcReady = 1'b1;
    waitDrain();
    repeat (4) @(negedge clk);
    summary();
  end

  initial begin
    repeat (WATCHDOG * 10) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    summary();
  end

endmodule